// File: doc/BRIEF.md
# Four-Bank Shuffle-Free Stage Memory Sequencer

This block sequences the stage memory that sits between a row of P parallel radix-2 butterflies and their own results. It holds two stage memories of four equal banks each. Each bank word carries P points. In each stage the block reads from one memory and writes to the other. The two memories swap roles at the end of every stage. Stage size N is a runtime input. Each bank holds N/(4P) words of the current stage.

On the read side, each beat reads one pair of banks at a shared address: first banks 0 and 2, then banks 1 and 3, then the address steps up. Lane i of the lower bank of the pair feeds butterfly i as its first operand. Lane i of the upper bank feeds it as the second operand, which is the point N/2 further on. On the write side, each beat stores 2P consecutive results into banks 0 and 1 at one shared address. Once those two banks are full, writing continues into banks 2 and 3 from address 0. This layout is exactly what the next stage's read pattern expects, so no data are ever reordered between stages.

The operand output and the result input are valid/ready streams. A read beat advances only when `rd_valid` and `rd_ready` are both high. While the beat is stalled, its address, bank enables and data hold steady. A result beat is stored only when `wr_valid` and `wr_ready` are both high. `wr_ready` stays low until a fixed latency after the first operand beat of the stage has been taken. It drops again after the last result beat. The control pins (`start`, `busy`, `done`, `cfg_err`) are plain levels and pulses.

Top module: `bank_shuffle_seq`

## Requirements
- R1: After reset, `busy`, `done`, `cfg_err`, `rd_valid` and `wr_ready` are all low.
- R2: A `start` with a legal `n_pts` while idle raises `busy` and `rd_valid` on the next cycle. Operand beat j uses bank enable mask 4'b0101 (banks 0 and 2, bit b = bank b) when j is even and 4'b1010 when j is odd, with `rd_addr` = j/2.
- R3: Lanes are W-bit fields, lane i at bits [W*i +: W]; result position q sits at `wr_data` bits [W*q +: W], and butterfly i delivers its two outputs at positions 2i and 2i+1. If the previous stage stored result beat k as points 2P*k+q, then operand beat j gives `rd_a` lane i = point P*j+i and `rd_b` lane i = point P*j+i+N/2.
- R4: Result beat k is written with `wr_addr` = k mod D, where D = N/(4P), into banks 0 and 1 (mask 4'b0011) for k < D and into banks 2 and 3 (mask 4'b1100) for k ≥ D; `wr_bank_en` is zero when no beat is stored.
- R5: `wr_ready` first rises exactly LAT cycles after the clock edge that accepts the stage's first operand beat, so no result is stored earlier.
- R6: A stage has exactly N/(2P) operand beats and N/(2P) result beats. After the last of each, `rd_valid` or `wr_ready` respectively stays low.
- R7: Once every beat of the stage has been accepted, `done` pulses high for one cycle, `busy` falls with it, and the next stage reads the memory that was just written.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_addr`, `rd_bank_en`, `rd_a` and `rd_b` hold their values. A cycle without `wr_valid` does not advance the write sequence.
- R9: A `start` whose `n_pts` is not a power of two, is below 4P or is above 4P*DMAX sets `cfg_err` and runs no stage. It also leaves the memory roles unchanged. The next accepted `start` clears `cfg_err`.
- R10: A `start` while `busy` is high is ignored, and `n_pts` is sampled only when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one stage |
| n_pts | input | NW | Stage size N in points |
| busy | output | 1 | Stage in progress |
| done | output | 1 | One-cycle pulse at stage end |
| cfg_err | output | 1 | Last start was rejected |
| rd_valid | output | 1 | Operand beat available |
| rd_ready | input | 1 | Butterflies take the operand beat |
| rd_a | output | P*W | First operands, lane i for butterfly i |
| rd_b | output | P*W | Second operands, N/2 apart |
| rd_bank_en | output | 4 | Banks being read, bit b = bank b |
| rd_addr | output | AW | Shared read word address |
| wr_valid | input | 1 | Result beat offered |
| wr_ready | output | 1 | Result beat can be stored |
| wr_data | input | 2*P*W | 2P consecutive results |
| wr_bank_en | output | 4 | Banks written this cycle |
| wr_addr | output | AW | Shared write word address |

## Verification
The bench writes a stage with tagged point indices and reads them back in the following stage. Any swap of bank pair order, any wrong half select or any off-by-one in the address gives operands that are not exactly N/2 apart. The smallest size, where each bank is one word deep, and the largest size, where the banks are full, catch mask and wrap errors. Irregular back-pressure on both streams, a start poked in mid-stage with a different size, and rejected starts placed between two stages target three faults: a design that drifts under stalls, one that re-latches the size, and one that swaps memories on a bad start. The exact cycle at which `wr_ready` opens and at which `done` pulses catches a latency gate that is off by one.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  localparam int BANKS = 4;
  // bank enable masks, bit b = bank b
  localparam logic [BANKS-1:0] RD_EVEN = 4'b0101;
  localparam logic [BANKS-1:0] RD_ODD  = 4'b1010;
  localparam logic [BANKS-1:0] WR_LOW  = 4'b0011;
  localparam logic [BANKS-1:0] WR_HIGH = 4'b1100;
endpackage

// File: rtl/fsq_cfg_check.sv
module fsq_cfg_check #(
  parameter int P    = 4,
  parameter int DMAX = 16,
  parameter int NW   = 10,
  parameter int BW   = 5
) (
  input  logic [NW-1:0] n_pts,
  output logic          ok,
  output logic [BW-1:0] dsz
);
  localparam int LG4P = $clog2(4 * P);
  localparam int NMAX = 4 * P * DMAX;

  logic [NW-1:0] nm1;
  logic          pow2;

  assign nm1  = n_pts - NW'(1);
  assign pow2 = (n_pts != '0) && ((n_pts & nm1) == '0);
  assign ok   = pow2 && (n_pts >= NW'(4 * P)) && (n_pts <= NW'(NMAX));
  assign dsz  = BW'(n_pts >> LG4P);
endmodule

// File: rtl/fsq_bank.sv
module fsq_bank #(
  parameter int WORDW = 64,
  parameter int DMAX  = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WORDW-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WORDW-1:0] rdata
);
  logic [WORDW-1:0] mem [DMAX];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fsq_rd_seq.sv
module fsq_rd_seq
  import fsq_pkg::*;
#(
  parameter int AW = 4,
  parameter int BW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [BW-1:0]    dsz,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic             rd_fire,
  output logic             pair,
  output logic [AW-1:0]    addr,
  output logic [BANKS-1:0] bank_en
);
  logic          active;
  logic [BW-1:0] j, last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      j      <= '0;
      last   <= '0;
    end else if (go) begin
      active <= 1'b1;
      j      <= '0;
      last   <= BW'({dsz - 1'b1, 1'b1});
    end else if (rd_fire) begin
      if (j == last) active <= 1'b0;
      else           j      <= j + BW'(1);
    end
  end

  assign rd_valid = active;
  assign rd_fire  = active && rd_ready;
  assign pair     = j[0];
  assign addr     = j[BW-1:1];
  assign bank_en  = active ? (pair ? RD_ODD : RD_EVEN) : '0;

  // R2
  pair_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && bank_en == RD_EVEN) |=> (rd_valid && bank_en == RD_ODD && addr == $past(addr)))
    else $error("odd pair must follow even pair at same address");

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !go) |=> (rd_valid && $stable(addr) && $stable(bank_en)))
    else $error("stalled operand beat moved");
endmodule

// File: rtl/fsq_wr_seq.sv
module fsq_wr_seq
  import fsq_pkg::*;
#(
  parameter int AW  = 4,
  parameter int BW  = 5,
  parameter int LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [BW-1:0]    dsz,
  input  logic             rd_fire,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic             wr_fire,
  output logic             active,
  output logic [AW-1:0]    addr,
  output logic [BANKS-1:0] bank_en
);
  localparam int LATW = $clog2(LAT + 1) + 1;

  logic            open, started, half;
  logic [LATW-1:0] lcnt;
  logic [BW-1:0]   k, last, dlat;
  logic [AW-1:0]   dmask;

  // latency gate: opens LAT edges after the first operand beat
  always_ff @(posedge clk) begin
    if (!rst_n || go) begin
      open    <= 1'b0;
      started <= 1'b0;
      lcnt    <= '0;
    end else if (!open) begin
      if (rd_fire && !started) begin
        started <= 1'b1;
        if (LAT <= 1) open <= 1'b1;
        else          lcnt <= LATW'(1);
      end else if (started) begin
        if (lcnt == LATW'(LAT - 1)) open <= 1'b1;
        else                        lcnt <= lcnt + LATW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      k      <= '0;
      last   <= '0;
      dlat   <= '0;
    end else if (go) begin
      active <= 1'b1;
      k      <= '0;
      last   <= BW'({dsz - 1'b1, 1'b1});
      dlat   <= dsz;
    end else if (wr_fire) begin
      if (k == last) active <= 1'b0;
      else           k      <= k + BW'(1);
    end
  end

  assign dmask    = AW'(dlat - 1'b1);
  assign half     = |(k & dlat);
  assign addr     = k[AW-1:0] & dmask;
  assign wr_ready = active && open;
  assign wr_fire  = wr_ready && wr_valid;
  assign bank_en  = wr_fire ? (half ? WR_HIGH : WR_LOW) : '0;

  // independent count of edges since the first operand beat
  logic [LATW-1:0] since_rd;
  always_ff @(posedge clk) begin
    if (!rst_n || go)                         since_rd <= '0;
    else if (since_rd == '0 && rd_fire)       since_rd <= LATW'(1);
    else if (since_rd != '0 && since_rd < LATW'(LAT)) since_rd <= since_rd + LATW'(1);
  end

  // R5
  wr_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (since_rd >= LATW'(LAT)))
    else $error("result stored before pipeline latency");

  // R4
  wr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && bank_en == WR_LOW && addr == dmask) |=> (!active || (half && addr == '0)))
    else $error("write did not move to upper banks at address 0");
endmodule

// File: rtl/bank_shuffle_seq.sv
module bank_shuffle_seq
  import fsq_pkg::*;
#(
  parameter int P    = 4,
  parameter int W    = 16,
  parameter int DMAX = 16,
  parameter int LAT  = 3,
  localparam int AW  = $clog2(DMAX),
  localparam int BW  = AW + 1,
  localparam int NW  = $clog2(4 * P * DMAX) + 2,
  localparam int LW  = P * W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NW-1:0]    n_pts,
  output logic             busy,
  output logic             done,
  output logic             cfg_err,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [LW-1:0]    rd_a,
  output logic [LW-1:0]    rd_b,
  output logic [BANKS-1:0] rd_bank_en,
  output logic [AW-1:0]    rd_addr,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [2*LW-1:0]  wr_data,
  output logic [BANKS-1:0] wr_bank_en,
  output logic [AW-1:0]    wr_addr
);
  logic          cfg_ok, go, rd_fire, rd_pair, wr_fire, wr_active, src_sel;
  logic [BW-1:0] dsz;
  logic [LW-1:0] rdat [2][BANKS];

  fsq_cfg_check #(.P(P), .DMAX(DMAX), .NW(NW), .BW(BW)) u_cfg (
    .n_pts(n_pts), .ok(cfg_ok), .dsz(dsz));

  assign go = start && !busy && cfg_ok;

  fsq_rd_seq #(.AW(AW), .BW(BW)) u_rd (
    .clk(clk), .rst_n(rst_n), .go(go), .dsz(dsz), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_fire(rd_fire), .pair(rd_pair),
    .addr(rd_addr), .bank_en(rd_bank_en));

  fsq_wr_seq #(.AW(AW), .BW(BW), .LAT(LAT)) u_wr (
    .clk(clk), .rst_n(rst_n), .go(go), .dsz(dsz), .rd_fire(rd_fire),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_fire(wr_fire),
    .active(wr_active), .addr(wr_addr), .bank_en(wr_bank_en));

  // two stage memories of four banks; set src_sel is read, the other written
  for (genvar s = 0; s < 2; s++) begin : g_set
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic we;
      assign we = wr_fire && (1'(s) != src_sel) && wr_bank_en[b];
      fsq_bank #(.WORDW(LW), .DMAX(DMAX), .AW(AW)) u_bank (
        .clk(clk), .we(we), .waddr(wr_addr),
        .wdata((b % 2 == 0) ? wr_data[LW-1:0] : wr_data[2*LW-1:LW]),
        .raddr(rd_addr), .rdata(rdat[s][b]));
    end
  end

  // lane mux: lower pair feeds first operands, upper pair the N/2 partners
  assign rd_a = rd_pair ? rdat[src_sel][1] : rdat[src_sel][0];
  assign rd_b = rd_pair ? rdat[src_sel][3] : rdat[src_sel][2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cfg_err <= 1'b0;
      src_sel <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        cfg_err <= !cfg_ok;
        if (cfg_ok) busy <= 1'b1;
      end else if (busy && !rd_valid && !wr_active) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        src_sel <= !src_sel;
      end
    end
  end

  // R9
  bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !cfg_ok) |=> (cfg_err && !busy && !rd_valid && $stable(src_sel)))
    else $error("rejected start launched a stage");

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !rd_valid && !wr_ready))
    else $error("done longer than one cycle");
endmodule

// File: tb/sim_bank_shuffle_seq.sv
module sim_bank_shuffle_seq;
  localparam int P = 4, W = 16, DMAX = 16, LAT = 3;
  localparam int AW = $clog2(DMAX), NW = $clog2(4 * P * DMAX) + 2, LW = P * W;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_ready = 1'b0, wr_valid = 1'b0;
  logic [NW-1:0] n_pts = '0;
  logic [2*LW-1:0] wr_data = '0;
  logic busy, done, cfg_err, rd_valid, wr_ready;
  logic [LW-1:0] rd_a, rd_b;
  logic [3:0] rd_bank_en, wr_bank_en;
  logic [AW-1:0] rd_addr, wr_addr;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  bank_shuffle_seq #(.P(P), .W(W), .DMAX(DMAX), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .n_pts(n_pts), .busy(busy), .done(done),
    .cfg_err(cfg_err), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_a(rd_a), .rd_b(rd_b),
    .rd_bank_en(rd_bank_en), .rd_addr(rd_addr), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_bank_en(wr_bank_en), .wr_addr(wr_addr));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pt(input logic [3:0] tag, input int idx);
    return {tag, 12'(idx)};
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk({busy, done, cfg_err, rd_valid, wr_ready} == 5'b0, "R1 idle after reset",
        {busy, done, cfg_err, rd_valid, wr_ready}, 0);
  endtask

  task automatic t_bad_start(input int n);
    @(negedge clk); start = 1'b1; n_pts = NW'(n);
    @(negedge clk); start = 1'b0; #1;
    chk(cfg_err == 1'b1, "R9 cfg_err set", cfg_err, 1);
    chk(!busy && !rd_valid, "R9 no stage on bad size", {busy, rd_valid}, 0);
    @(negedge clk); #1;
    chk(!busy && !rd_valid && !wr_ready, "R9 still idle", {busy, rd_valid, wr_ready}, 0);
  endtask

  // one stage: writes tagged points; optionally checks operands against ptag
  task automatic t_stage(input int n, input logic [3:0] tag, input bit vchk,
                         input logic [3:0] ptag, input bit stall, input bit poke);
    int beats = n / (2 * P), d = n / (4 * P);
    int j = 0, k = 0, cyc = 0, c0 = 0;
    bit seen = 0, prev_stall = 0, bad_rv = 0, bad_wr = 0;
    logic [AW-1:0] s_addr = '0; logic [3:0] s_en = '0; logic [LW-1:0] s_a = '0, s_b = '0;
    @(negedge clk); start = 1'b1; n_pts = NW'(n);
    @(negedge clk); start = 1'b0; #1;
    chk(busy && rd_valid, "R2 busy and rd_valid after start", {busy, rd_valid}, 2'b11);
    chk(!cfg_err, "R9 cfg_err cleared by good start", cfg_err, 0);
    while (j < beats || k < beats) begin
      @(negedge clk);
      rd_ready = stall ? (cyc % 3 != 0) : 1'b1;
      wr_valid = stall ? (cyc % 4 != 1) : 1'b1;
      start = poke && (cyc == 5);          // R10 start while busy
      n_pts = (poke && cyc == 5) ? NW'(16) : NW'(n);
      for (int q = 0; q < 2 * P; q++) wr_data[q*W +: W] = pt(tag, 2 * P * k + q);
      #1;
      if (rd_valid != (j < beats)) bad_rv = 1;
      if (wr_ready != (seen && cyc >= c0 + LAT && k < beats)) bad_wr = 1;
      if (prev_stall)
        chk(rd_valid && rd_addr == s_addr && rd_bank_en == s_en && rd_a == s_a && rd_b == s_b,
            "R8 stalled beat held", {rd_addr, rd_bank_en}, {s_addr, s_en});
      if (rd_valid && rd_ready) begin
        chk(rd_bank_en == ((j % 2) ? 4'b1010 : 4'b0101), "R2 read bank pair", rd_bank_en,
            (j % 2) ? 4'b1010 : 4'b0101);
        chk(rd_addr == AW'(j / 2), "R2 read address", rd_addr, j / 2);
        if (vchk)
          for (int i = 0; i < P; i++) begin
            chk(rd_a[i*W +: W] == pt(ptag, P * j + i), "R3 operand A", rd_a[i*W +: W],
                pt(ptag, P * j + i));
            chk(rd_b[i*W +: W] == pt(ptag, P * j + i + n / 2), "R3 operand B N/2 apart",
                rd_b[i*W +: W], pt(ptag, P * j + i + n / 2));
          end
        if (j == 0) begin seen = 1; c0 = cyc; end
        j++;
      end
      prev_stall = rd_valid && !rd_ready;
      if (prev_stall) begin s_addr = rd_addr; s_en = rd_bank_en; s_a = rd_a; s_b = rd_b; end
      if (wr_ready && wr_valid) begin
        chk(wr_bank_en == ((k < d) ? 4'b0011 : 4'b1100), "R4 write bank pair", wr_bank_en,
            (k < d) ? 4'b0011 : 4'b1100);
        chk(wr_addr == AW'(k % d), "R4 write address", wr_addr, k % d);
        k++;
      end
      cyc++;
      if (cyc > 2000) begin k = beats; j = beats; bad_rv = 1; end
    end
    chk(!bad_rv, "R6 rd_valid span", bad_rv, 0);
    chk(!bad_wr, "R5 wr_ready opens LAT after first read", bad_wr, 0);
    @(negedge clk); rd_ready = 1'b0; wr_valid = 1'b0; start = 1'b0; #1;
    chk(busy && !done && !rd_valid && !wr_ready && wr_bank_en == 0, "R6 streams closed",
        {busy, done, rd_valid, wr_ready}, 4'b1000);
    @(negedge clk); #1;
    chk(done && !busy, "R7 done pulse", {done, busy}, 2'b10);
    @(negedge clk); #1;
    chk(!done && !busy && !rd_valid, "R7 single pulse, R10 no restart", {done, busy, rd_valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_stage(64, 4'h1, 1'b0, 4'h0, 1'b0, 1'b0);   // fill set 1
    t_stage(64, 4'h2, 1'b1, 4'h1, 1'b1, 1'b1);   // read back under stalls, poke start
    t_bad_start(48);                              // not a power of two
    t_bad_start(8);                               // below 4P
    t_bad_start(512);                             // above capacity
    t_stage(64, 4'h3, 1'b1, 4'h2, 1'b0, 1'b0);   // roles not swapped by rejects (R9)
    t_stage(16, 4'h4, 1'b0, 4'h0, 1'b0, 1'b0);   // one-word banks
    t_stage(16, 4'h5, 1'b1, 4'h4, 1'b1, 1'b0);
    t_stage(256, 4'h6, 1'b0, 4'h0, 1'b0, 1'b0);  // full banks
    t_stage(256, 4'h7, 1'b1, 4'h6, 1'b1, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule